// File: doc/BRIEF.md
# Page-Walk Descriptor Fetch Unit

This unit sits between a stage-1 table walker and memory. The walker hands it one request at a time: the address of a descriptor, whether the descriptor is 32 or 64 bits wide, and whether the walk runs in secure state. When two-stage translation is in force, the unit first sends the table address to a stage-2 translation port. It then checks the returned memory attributes against a walk-protection rule and picks the physical address space. It issues one read on a valid/ready memory port and arranges the returned bytes for the regime's byte order. Last, it hands back either the descriptor or a fault record.

All configuration inputs are sampled when a request is accepted and are held for the rest of that fetch. Only one fetch is ever in flight. The `busy` output covers the whole span from acceptance until the response is taken.

Top module: `walk_fetch_unit`

## Requirements
- R1: `req_ready` is high only when no fetch is in flight. `busy` rises in the cycle after a request is accepted and falls in the cycle after the response is taken. At most one of the stage-2 request, memory request and walker response valids is high in any cycle, and a response held against `rsp_ready` low keeps its data.
- R2: With `cfg_two_stage` low, no stage-2 request is made, and the memory read uses the table address unchanged, with `mem_req_secure` equal to `req_secure`.
- R3: With `cfg_two_stage` high, the stage-2 request carries the table address and `req_secure`. If that stage succeeds, the memory read uses the returned physical address.
- R4: A stage-2 fault response ends the fetch without a memory read. The response reports fault = 1, passes the stage-2 fault type through unchanged, sets `rsp_ipa` to the table address, sets `rsp_s2_stage` = `rsp_on_walk` = 1 and `rsp_walk_ns` = NOT `req_secure`, and returns data 0.
- R5: Stage-2 attributes count as Device memory as follows. With `cfg_force_wb` = 1, they are Device when attr[2] = 0. With `cfg_force_wb` = 0, they are Device when attr[3:2] = 00.
- R6: When `cfg_walk_prot` = 1 and the attributes are Device, the fetch ends without a read as a Permission fault (type 4'd3), recorded as in R4. When `cfg_walk_prot` = 0, Device attributes do not block the read.
- R7: After a successful stage-2 step with `cfg_sec_below` = 1, the read space is chosen by the walk state. A secure walk goes to secure space (`mem_req_secure` = 1) unless `cfg_sw_ns` = 1. A non-secure walk goes to secure space unless `cfg_nsw_ns` = 1.
- R8: After a successful stage-2 step with `cfg_sec_below` = 0, a secure walk is illegal. It ends without a read as fault type 4'd15 with the stage flags clear. A non-secure walk reads from non-secure space.
- R9: A 64-bit fetch returns the 64-bit memory beat unchanged when `cfg_big_end` = 0, and byte-reversed when `cfg_big_end` = 1.
- R10: A 32-bit fetch takes the word at bits [63:32] of the beat when address bit 2 is 1, and bits [31:0] otherwise. It byte-reverses that word when `cfg_big_end` = 1 and returns it zero-extended.
- R11: A memory response with `mem_rsp_err` = 1 gives fault type 4'd7. `rsp_ea_type` then equals `mem_rsp_etype`, the stage flags are clear and the data is 0.
- R12: A fetch without a fault reports fault = 0, type 0, `rsp_ea_type` = 0, `rsp_ipa` = 0, and all three stage flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Walker request valid |
| req_ready | output | 1 | Unit can accept a request |
| req_addr | input | AW | Descriptor table address |
| req_is64 | input | 1 | 1 = 64-bit descriptor, 0 = 32-bit |
| req_secure | input | 1 | Walk runs in secure state |
| cfg_two_stage | input | 1 | Regime is stage 1 of two and stage 2 is enabled |
| cfg_force_wb | input | 1 | Force-write-back control for the Device test |
| cfg_walk_prot | input | 1 | Fault walks that land in stage-2 Device memory |
| cfg_big_end | input | 1 | Regime descriptors are big-endian |
| cfg_sec_below | input | 1 | Running secure below the top exception level |
| cfg_sw_ns | input | 1 | Secure walks go to non-secure space |
| cfg_nsw_ns | input | 1 | Non-secure walks go to non-secure space |
| s2_req_valid | output | 1 | Stage-2 translation request valid |
| s2_req_ready | input | 1 | Stage-2 port accepts request |
| s2_req_addr | output | AW | Address to translate |
| s2_req_secure | output | 1 | Secure bit of the walk |
| s2_rsp_valid | input | 1 | Stage-2 response valid (one cycle) |
| s2_rsp_pa | input | AW | Translated physical address |
| s2_rsp_attr | input | 4 | Stage-2 memory attributes |
| s2_rsp_fault | input | 1 | Stage-2 translation faulted |
| s2_rsp_ftype | input | 4 | Stage-2 fault type |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | AW | Read address |
| mem_req_secure | output | 1 | 1 = secure space |
| mem_req_is64 | output | 1 | Fetch size |
| mem_rsp_valid | input | 1 | Memory response valid (one cycle) |
| mem_rsp_data | input | DW | Read beat |
| mem_rsp_err | input | 1 | Read error |
| mem_rsp_etype | input | ETW | External-abort type |
| rsp_valid | output | 1 | Walker response valid |
| rsp_ready | input | 1 | Walker takes response |
| rsp_data | output | DW | Descriptor data |
| rsp_fault | output | 1 | Fetch faulted |
| rsp_ftype | output | 4 | Fault type |
| rsp_ea_type | output | ETW | External-abort type |
| rsp_ipa | output | AW | Table address recorded on a stage-2 walk fault |
| rsp_s2_stage | output | 1 | Fault arose in stage 2 |
| rsp_on_walk | output | 1 | Fault arose on the stage-1 walk |
| rsp_walk_ns | output | 1 | Faulting walk was non-secure |
| busy | output | 1 | Fetch in flight |

## Verification
The properties assume that the stage-2 and memory ports each answer with a single-cycle response valid, only after their request has been accepted, and never otherwise. They also assume the walker holds its configuration steady while `busy` is high. The bench's port models issue a response exactly one cycle after each acceptance and drive random ready stalls only on the request side. The bench changes configuration only between fetches, so every random fetch stays inside these assumptions.

// File: rtl/wfu_pkg.sv
package wfu_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_S2_REQ,
    ST_S2_WAIT,
    ST_MEM_REQ,
    ST_MEM_WAIT,
    ST_RESP
  } wfu_state_e;

  localparam int unsigned FT_W = 4;

  localparam logic [FT_W-1:0] FT_NONE       = 4'd0;
  localparam logic [FT_W-1:0] FT_PERMISSION = 4'd3;
  localparam logic [FT_W-1:0] FT_EXT_WALK   = 4'd7;
  localparam logic [FT_W-1:0] FT_BAD_SECURE = 4'd15;

  typedef struct packed {
    logic two_stage;
    logic force_wb;
    logic walk_prot;
    logic big_end;
    logic sec_below;
    logic sw_to_ns;
    logic nsw_to_ns;
  } wfu_cfg_t;

endpackage

// File: rtl/wfu_s2_eval.sv
module wfu_s2_eval
  import wfu_pkg::*;
(
  input  logic            i_force_wb,
  input  logic            i_walk_prot,
  input  logic            i_sec_below,
  input  logic            i_sw_ns,
  input  logic            i_nsw_ns,
  input  logic            i_req_sec,
  input  logic            i_s2_fault,
  input  logic [FT_W-1:0] i_s2_ftype,
  input  logic [3:0]      i_attr,
  output logic            o_fault,
  output logic [FT_W-1:0] o_ftype,
  output logic            o_s2_flag,
  output logic            o_space_sec
);

  logic is_device;
  logic attr_unused;

  assign attr_unused = ^i_attr[1:0];

  // Device classification of the stage-2 attributes
  assign is_device = i_force_wb ? ~i_attr[2] : (i_attr[3:2] == 2'b00);

  always_comb begin
    o_fault   = 1'b0;
    o_ftype   = FT_NONE;
    o_s2_flag = 1'b0;
    if (i_s2_fault) begin
      o_fault   = 1'b1;
      o_ftype   = i_s2_ftype;
      o_s2_flag = 1'b1;
    end else if (i_walk_prot && is_device) begin
      o_fault   = 1'b1;
      o_ftype   = FT_PERMISSION;
      o_s2_flag = 1'b1;
    end else if (!i_sec_below && i_req_sec) begin
      o_fault   = 1'b1;
      o_ftype   = FT_BAD_SECURE;
    end
  end

  // Output space: 1 = secure
  assign o_space_sec = i_sec_below ? (i_req_sec ? ~i_sw_ns : ~i_nsw_ns) : 1'b0;

endmodule

// File: rtl/wfu_data_fmt.sv
module wfu_data_fmt #(
  parameter int unsigned DW = 64
) (
  input  logic [DW-1:0] i_raw,
  input  logic          i_is64,
  input  logic          i_lane,
  input  logic          i_big_end,
  output logic [DW-1:0] o_data
);

  localparam int unsigned NB  = DW / 8;
  localparam int unsigned HW  = DW / 2;
  localparam int unsigned NBH = NB / 2;

  logic [DW-1:0] rev_full;
  logic [HW-1:0] word;
  logic [HW-1:0] rev_word;

  assign word = i_lane ? i_raw[DW-1:HW] : i_raw[HW-1:0];

  for (genvar g = 0; g < NB; g++) begin : g_rev_full
    assign rev_full[g*8 +: 8] = i_raw[(NB-1-g)*8 +: 8];
  end

  for (genvar g = 0; g < NBH; g++) begin : g_rev_word
    assign rev_word[g*8 +: 8] = word[(NBH-1-g)*8 +: 8];
  end

  always_comb begin
    if (i_is64) begin
      o_data = i_big_end ? rev_full : i_raw;
    end else begin
      o_data = {{HW{1'b0}}, (i_big_end ? rev_word : word)};
    end
  end

endmodule

// File: rtl/wfu_seq.sv
module wfu_seq
  import wfu_pkg::*;
#(
  parameter int unsigned AW  = 40,
  parameter int unsigned DW  = 64,
  parameter int unsigned ETW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_addr,
  input  logic            req_is64,
  input  logic            req_secure,
  input  wfu_cfg_t        req_cfg,
  output wfu_cfg_t        cfg_q,
  output logic            sec_q,
  output logic            s2_req_valid,
  input  logic            s2_req_ready,
  output logic [AW-1:0]   s2_req_addr,
  input  logic            s2_rsp_valid,
  input  logic [AW-1:0]   s2_rsp_pa,
  input  logic            ev_fault,
  input  logic [FT_W-1:0] ev_ftype,
  input  logic            ev_s2_flag,
  input  logic            ev_space_sec,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [AW-1:0]   mem_req_addr,
  output logic            mem_req_secure,
  output logic            mem_req_is64,
  input  logic            mem_rsp_valid,
  input  logic            mem_rsp_err,
  input  logic [ETW-1:0]  mem_rsp_etype,
  input  logic [DW-1:0]   fmt_data,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [DW-1:0]   rsp_data,
  output logic            rsp_fault,
  output logic [FT_W-1:0] rsp_ftype,
  output logic [ETW-1:0]  rsp_ea_type,
  output logic [AW-1:0]   rsp_ipa,
  output logic            rsp_s2_stage,
  output logic            rsp_on_walk,
  output logic            rsp_walk_ns,
  output logic            busy
);

  wfu_state_e state_q, state_d;

  logic [AW-1:0]   tbl_q;
  logic            is64_q;
  logic [AW-1:0]   maddr_q, maddr_d;
  logic            mspace_q, mspace_d;
  logic [DW-1:0]   res_data_q, res_data_d;
  logic            res_fault_q, res_fault_d;
  logic [FT_W-1:0] res_ftype_q, res_ftype_d;
  logic [ETW-1:0]  res_ea_q, res_ea_d;
  logic            res_s2_q, res_s2_d;

  logic en_req, en_s2, en_mem, en_maddr, en_res;

  assign en_req   = (state_q == ST_IDLE) && req_valid;
  assign en_s2    = (state_q == ST_S2_WAIT) && s2_rsp_valid;
  assign en_mem   = (state_q == ST_MEM_WAIT) && mem_rsp_valid;
  assign en_maddr = en_req || (en_s2 && !ev_fault);
  assign en_res   = (en_s2 && ev_fault) || en_mem;

  // Next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (req_valid) state_d = req_cfg.two_stage ? ST_S2_REQ : ST_MEM_REQ;
      ST_S2_REQ:   if (s2_req_ready) state_d = ST_S2_WAIT;
      ST_S2_WAIT:  if (s2_rsp_valid) state_d = ev_fault ? ST_RESP : ST_MEM_REQ;
      ST_MEM_REQ:  if (mem_req_ready) state_d = ST_MEM_WAIT;
      ST_MEM_WAIT: if (mem_rsp_valid) state_d = ST_RESP;
      ST_RESP:     if (rsp_ready) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  // Next values of the datapath registers
  always_comb begin
    maddr_d     = en_req ? req_addr : s2_rsp_pa;
    mspace_d    = en_req ? req_secure : ev_space_sec;
    res_data_d  = (en_mem && !mem_rsp_err) ? fmt_data : '0;
    res_fault_d = en_s2 ? 1'b1 : mem_rsp_err;
    res_ftype_d = en_s2 ? ev_ftype : (mem_rsp_err ? FT_EXT_WALK : FT_NONE);
    res_ea_d    = (!en_s2 && mem_rsp_err) ? mem_rsp_etype : '0;
    res_s2_d    = en_s2 ? ev_s2_flag : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_q  <= '0;
      is64_q <= 1'b0;
      sec_q  <= 1'b0;
      cfg_q  <= '0;
    end else if (en_req) begin
      tbl_q  <= req_addr;
      is64_q <= req_is64;
      sec_q  <= req_secure;
      cfg_q  <= req_cfg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maddr_q  <= '0;
      mspace_q <= 1'b0;
    end else if (en_maddr) begin
      maddr_q  <= maddr_d;
      mspace_q <= mspace_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_data_q  <= '0;
      res_fault_q <= 1'b0;
      res_ftype_q <= FT_NONE;
      res_ea_q    <= '0;
      res_s2_q    <= 1'b0;
    end else if (en_res) begin
      res_data_q  <= res_data_d;
      res_fault_q <= res_fault_d;
      res_ftype_q <= res_ftype_d;
      res_ea_q    <= res_ea_d;
      res_s2_q    <= res_s2_d;
    end
  end

  assign req_ready      = (state_q == ST_IDLE);
  assign busy           = (state_q != ST_IDLE);
  assign s2_req_valid   = (state_q == ST_S2_REQ);
  assign s2_req_addr    = tbl_q;
  assign mem_req_valid  = (state_q == ST_MEM_REQ);
  assign mem_req_addr   = maddr_q;
  assign mem_req_secure = mspace_q;
  assign mem_req_is64   = is64_q;

  assign rsp_valid    = (state_q == ST_RESP);
  assign rsp_data     = res_data_q;
  assign rsp_fault    = res_fault_q;
  assign rsp_ftype    = res_ftype_q;
  assign rsp_ea_type  = res_ea_q;
  assign rsp_ipa      = res_s2_q ? tbl_q : '0;
  assign rsp_s2_stage = res_s2_q;
  assign rsp_on_walk  = res_s2_q;
  assign rsp_walk_ns  = res_s2_q & ~sec_q;

endmodule

// File: rtl/walk_fetch_unit.sv
module walk_fetch_unit
  import wfu_pkg::*;
#(
  parameter int unsigned AW  = 40,
  parameter int unsigned DW  = 64,
  parameter int unsigned ETW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_addr,
  input  logic            req_is64,
  input  logic            req_secure,
  input  logic            cfg_two_stage,
  input  logic            cfg_force_wb,
  input  logic            cfg_walk_prot,
  input  logic            cfg_big_end,
  input  logic            cfg_sec_below,
  input  logic            cfg_sw_ns,
  input  logic            cfg_nsw_ns,
  output logic            s2_req_valid,
  input  logic            s2_req_ready,
  output logic [AW-1:0]   s2_req_addr,
  output logic            s2_req_secure,
  input  logic            s2_rsp_valid,
  input  logic [AW-1:0]   s2_rsp_pa,
  input  logic [3:0]      s2_rsp_attr,
  input  logic            s2_rsp_fault,
  input  logic [3:0]      s2_rsp_ftype,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [AW-1:0]   mem_req_addr,
  output logic            mem_req_secure,
  output logic            mem_req_is64,
  input  logic            mem_rsp_valid,
  input  logic [DW-1:0]   mem_rsp_data,
  input  logic            mem_rsp_err,
  input  logic [ETW-1:0]  mem_rsp_etype,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [DW-1:0]   rsp_data,
  output logic            rsp_fault,
  output logic [3:0]      rsp_ftype,
  output logic [ETW-1:0]  rsp_ea_type,
  output logic [AW-1:0]   rsp_ipa,
  output logic            rsp_s2_stage,
  output logic            rsp_on_walk,
  output logic            rsp_walk_ns,
  output logic            busy
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_s_n = rst_sync_q[1];

  wfu_cfg_t        cfg_in, cfg_q;
  logic            sec_q;
  logic            cfg_unused;
  logic            ev_fault, ev_s2_flag, ev_space_sec;
  logic [FT_W-1:0] ev_ftype;
  logic [DW-1:0]   fmt_data;

  assign cfg_in = '{two_stage: cfg_two_stage, force_wb: cfg_force_wb,
                    walk_prot: cfg_walk_prot, big_end: cfg_big_end,
                    sec_below: cfg_sec_below, sw_to_ns: cfg_sw_ns,
                    nsw_to_ns: cfg_nsw_ns};

  assign cfg_unused    = cfg_q.two_stage;
  assign s2_req_secure = sec_q;

  wfu_s2_eval u_eval (
    .i_force_wb  (cfg_q.force_wb),
    .i_walk_prot (cfg_q.walk_prot),
    .i_sec_below (cfg_q.sec_below),
    .i_sw_ns     (cfg_q.sw_to_ns),
    .i_nsw_ns    (cfg_q.nsw_to_ns),
    .i_req_sec   (sec_q),
    .i_s2_fault  (s2_rsp_fault),
    .i_s2_ftype  (s2_rsp_ftype),
    .i_attr      (s2_rsp_attr),
    .o_fault     (ev_fault),
    .o_ftype     (ev_ftype),
    .o_s2_flag   (ev_s2_flag),
    .o_space_sec (ev_space_sec)
  );

  wfu_data_fmt #(.DW(DW)) u_fmt (
    .i_raw     (mem_rsp_data),
    .i_is64    (mem_req_is64),
    .i_lane    (mem_req_addr[2]),
    .i_big_end (cfg_q.big_end),
    .o_data    (fmt_data)
  );

  wfu_seq #(.AW(AW), .DW(DW), .ETW(ETW)) u_seq (
    .clk            (clk),
    .rst_n          (rst_s_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_addr       (req_addr),
    .req_is64       (req_is64),
    .req_secure     (req_secure),
    .req_cfg        (cfg_in),
    .cfg_q          (cfg_q),
    .sec_q          (sec_q),
    .s2_req_valid   (s2_req_valid),
    .s2_req_ready   (s2_req_ready),
    .s2_req_addr    (s2_req_addr),
    .s2_rsp_valid   (s2_rsp_valid),
    .s2_rsp_pa      (s2_rsp_pa),
    .ev_fault       (ev_fault),
    .ev_ftype       (ev_ftype),
    .ev_s2_flag     (ev_s2_flag),
    .ev_space_sec   (ev_space_sec),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_req_addr   (mem_req_addr),
    .mem_req_secure (mem_req_secure),
    .mem_req_is64   (mem_req_is64),
    .mem_rsp_valid  (mem_rsp_valid),
    .mem_rsp_err    (mem_rsp_err),
    .mem_rsp_etype  (mem_rsp_etype),
    .fmt_data       (fmt_data),
    .rsp_valid      (rsp_valid),
    .rsp_ready      (rsp_ready),
    .rsp_data       (rsp_data),
    .rsp_fault      (rsp_fault),
    .rsp_ftype      (rsp_ftype),
    .rsp_ea_type    (rsp_ea_type),
    .rsp_ipa        (rsp_ipa),
    .rsp_s2_stage   (rsp_s2_stage),
    .rsp_on_walk    (rsp_on_walk),
    .rsp_walk_ns    (rsp_walk_ns),
    .busy           (busy)
  );

endmodule

// File: rtl/wfu_checker.sv
module wfu_checker
  import wfu_pkg::*;
#(
  parameter int unsigned AW  = 40,
  parameter int unsigned DW  = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          s2_req_valid,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_data,
  input logic          rsp_fault,
  input logic [3:0]    rsp_ftype,
  input logic          rsp_s2_stage,
  input logic          rsp_on_walk,
  input logic          rsp_walk_ns,
  input logic          busy
);

  a_r1_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({s2_req_valid, mem_req_valid, rsp_valid}));

  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  a_r1_idle_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> (!busy && req_ready));

  a_r1_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_fault)));

  a_r3_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r4_fault_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_data == '0));

  a_r4_stage_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_s2_stage) |-> (rsp_on_walk && rsp_fault));

  a_r11_ext_not_stage2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ftype == FT_EXT_WALK && !rsp_s2_stage) |-> rsp_fault);

  a_r12_clean_response: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (!rsp_s2_stage && !rsp_on_walk && !rsp_walk_ns && rsp_ftype == FT_NONE));

endmodule

bind walk_fetch_unit wfu_checker #(.AW(AW), .DW(DW)) u_wfu_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .s2_req_valid  (s2_req_valid),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_data      (rsp_data),
  .rsp_fault     (rsp_fault),
  .rsp_ftype     (rsp_ftype),
  .rsp_s2_stage  (rsp_s2_stage),
  .rsp_on_walk   (rsp_on_walk),
  .rsp_walk_ns   (rsp_walk_ns),
  .busy          (busy)
);

// File: tb/walk_fetch_unit_bench.sv
module walk_fetch_unit_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned AW  = 40;
  localparam int unsigned DW  = 64;
  localparam int unsigned ETW = 2;
  localparam logic [AW-1:0] PA_XOR = 40'h00_5A00_0000;

  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic            req_valid, req_ready, req_is64, req_secure;
  logic [AW-1:0]   req_addr;
  logic            cfg_two_stage, cfg_force_wb, cfg_walk_prot, cfg_big_end;
  logic            cfg_sec_below, cfg_sw_ns, cfg_nsw_ns;
  logic            s2_req_valid, s2_req_ready, s2_req_secure;
  logic [AW-1:0]   s2_req_addr, s2_rsp_pa;
  logic            s2_rsp_valid, s2_rsp_fault;
  logic [3:0]      s2_rsp_attr, s2_rsp_ftype;
  logic            mem_req_valid, mem_req_ready, mem_req_secure, mem_req_is64;
  logic [AW-1:0]   mem_req_addr;
  logic            mem_rsp_valid, mem_rsp_err;
  logic [DW-1:0]   mem_rsp_data;
  logic [ETW-1:0]  mem_rsp_etype;
  logic            rsp_valid, rsp_ready, rsp_fault;
  logic [DW-1:0]   rsp_data;
  logic [3:0]      rsp_ftype;
  logic [ETW-1:0]  rsp_ea_type;
  logic [AW-1:0]   rsp_ipa;
  logic            rsp_s2_stage, rsp_on_walk, rsp_walk_ns, busy;

  walk_fetch_unit #(.AW(AW), .DW(DW), .ETW(ETW)) u_walk_fetch_unit (.*);

  int checks = 0;
  int fails  = 0;

  // Model behaviour knobs
  logic       b_s2_fault;
  logic [3:0] b_s2_ftype, b_attr;
  logic       b_merr;
  logic [1:0] b_metype;

  // Model observations
  int            s2_cnt = 0, m_cnt = 0;
  logic [AW-1:0] s2_seen_addr, m_seen_addr;
  logic          s2_seen_sec, m_seen_sec, m_seen_is64;

  function automatic logic [DW-1:0] memfn(input logic [AW-1:0] a);
    return {a[31:0] ^ 32'h0F1E2D3C, a[31:0] + 32'h13579BDF};
  endfunction

  function automatic logic [63:0] bswap64(input logic [63:0] v);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[i*8 +: 8] = v[(7-i)*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] bswap32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[i*8 +: 8] = v[(3-i)*8 +: 8];
    return r;
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Stage-2 port model: one-cycle response after each acceptance
  initial begin
    logic          pend;
    logic [AW-1:0] pa;
    pend = 1'b0;
    s2_req_ready = 1'b0; s2_rsp_valid = 1'b0; s2_rsp_pa = '0;
    s2_rsp_attr = '0; s2_rsp_fault = 1'b0; s2_rsp_ftype = '0;
    forever begin
      @(negedge clk);
      if (pend) begin
        s2_rsp_valid = 1'b1;
        s2_rsp_pa    = pa;
        s2_rsp_attr  = b_attr;
        s2_rsp_fault = b_s2_fault;
        s2_rsp_ftype = b_s2_ftype;
        pend = 1'b0;
      end else begin
        s2_rsp_valid = 1'b0;
      end
      s2_req_ready = ($urandom % 3) != 0;
      if (s2_req_valid && s2_req_ready) begin
        pend = 1'b1;
        pa = s2_req_addr ^ PA_XOR;
        s2_seen_addr = s2_req_addr;
        s2_seen_sec  = s2_req_secure;
        s2_cnt++;
      end
    end
  end

  // Memory port model
  initial begin
    logic          pend;
    logic [AW-1:0] a;
    pend = 1'b0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    mem_rsp_err = 1'b0; mem_rsp_etype = '0;
    forever begin
      @(negedge clk);
      if (pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = memfn(a);
        mem_rsp_err   = b_merr;
        mem_rsp_etype = b_metype;
        pend = 1'b0;
      end else begin
        mem_rsp_valid = 1'b0;
      end
      mem_req_ready = ($urandom % 3) != 0;
      if (mem_req_valid && mem_req_ready) begin
        pend = 1'b1;
        a = mem_req_addr;
        m_seen_addr = mem_req_addr;
        m_seen_sec  = mem_req_secure;
        m_seen_is64 = mem_req_is64;
        m_cnt++;
      end
    end
  end

  task automatic run_case(input string tag,
                          input logic [AW-1:0] addr, input bit is64, input bit sec,
                          input bit two, input bit fwb, input bit prot, input bit be,
                          input bit sbel, input bit sw, input bit nsw,
                          input bit s2f, input logic [3:0] s2ft, input logic [3:0] attr,
                          input bit merr, input logic [1:0] met);
    bit            dev, exp_fault, exp_s2, do_read, exp_space;
    logic [3:0]    exp_ft;
    logic [1:0]    exp_ea;
    logic [AW-1:0] exp_maddr, exp_ipa;
    logic [63:0]   raw, exp_data;
    int            s2c0, mc0;

    // Expected result from the requirements
    dev = fwb ? !attr[2] : (attr[3:2] == 2'b00);
    exp_fault = 0; exp_s2 = 0; do_read = 1; exp_ft = 4'd0; exp_ea = 2'd0;
    exp_maddr = addr; exp_space = sec; exp_data = '0;
    if (two) begin
      if (s2f) begin
        exp_fault = 1; exp_s2 = 1; do_read = 0; exp_ft = s2ft;
      end else if (prot && dev) begin
        exp_fault = 1; exp_s2 = 1; do_read = 0; exp_ft = 4'd3;
      end else if (!sbel && sec) begin
        exp_fault = 1; do_read = 0; exp_ft = 4'd15;
      end else begin
        exp_maddr = addr ^ PA_XOR;
        exp_space = sbel ? (sec ? !sw : !nsw) : 1'b0;
      end
    end
    if (do_read) begin
      if (merr) begin
        exp_fault = 1; exp_ft = 4'd7; exp_ea = met;
      end else begin
        raw = memfn(exp_maddr);
        if (is64) exp_data = be ? bswap64(raw) : raw;
        else begin
          exp_data[31:0] = exp_maddr[2] ? raw[63:32] : raw[31:0];
          if (be) exp_data[31:0] = bswap32(exp_data[31:0]);
        end
      end
    end
    exp_ipa = exp_s2 ? addr : '0;

    // Drive stimulus
    @(negedge clk);
    b_s2_fault = s2f; b_s2_ftype = s2ft; b_attr = attr; b_merr = merr; b_metype = met;
    cfg_two_stage = two; cfg_force_wb = fwb; cfg_walk_prot = prot; cfg_big_end = be;
    cfg_sec_below = sbel; cfg_sw_ns = sw; cfg_nsw_ns = nsw;
    req_addr = addr; req_is64 = is64; req_secure = sec; req_valid = 1'b1;
    s2c0 = s2_cnt; mc0 = m_cnt;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1, {tag, " R1 busy after accept"}, busy, 1);

    while (!rsp_valid) @(negedge clk);
    repeat ($urandom % 3) begin
      @(negedge clk);
      chk(rsp_valid === 1'b1, {tag, " R1 response held"}, rsp_valid, 1);
    end

    chk((s2_cnt - s2c0) == (two ? 1 : 0), {tag, " R2/R3 stage-2 request count"}, s2_cnt - s2c0, two);
    if (two) begin
      chk(s2_seen_addr === addr && s2_seen_sec === sec, {tag, " R3 stage-2 request fields"},
          {s2_seen_sec, s2_seen_addr}, {sec, addr});
    end
    chk((m_cnt - mc0) == (do_read ? 1 : 0), {tag, " R4/R6/R8 memory read count"}, m_cnt - mc0, do_read);
    if (do_read) begin
      chk(m_seen_addr === exp_maddr, {tag, " R2/R3 read address"}, m_seen_addr, exp_maddr);
      chk(m_seen_sec === exp_space, {tag, " R2/R7/R8 read space"}, m_seen_sec, exp_space);
      chk(m_seen_is64 === is64, {tag, " R9/R10 read size"}, m_seen_is64, is64);
    end
    chk(rsp_data === exp_data, {tag, " R9/R10/R11 data"}, rsp_data, exp_data);
    chk(rsp_fault === exp_fault, {tag, " R4/R11/R12 fault flag"}, rsp_fault, exp_fault);
    chk(rsp_ftype === exp_ft, {tag, " R4/R5/R6/R8/R11 fault type"}, rsp_ftype, exp_ft);
    chk(rsp_ea_type === exp_ea, {tag, " R11 abort type"}, rsp_ea_type, exp_ea);
    chk(rsp_ipa === exp_ipa, {tag, " R4/R12 recorded address"}, rsp_ipa, exp_ipa);
    chk({rsp_s2_stage, rsp_on_walk, rsp_walk_ns} === {exp_s2, exp_s2, exp_s2 & !sec},
        {tag, " R4/R12 stage flags"}, {rsp_s2_stage, rsp_on_walk, rsp_walk_ns},
        {exp_s2, exp_s2, exp_s2 & !sec});

    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(busy === 1'b0 && rsp_valid === 1'b0, {tag, " R1 idle after take"}, {busy, rsp_valid}, 0);
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog act=hung exp=complete");
    finish_run();
  end

  initial begin
    void'($urandom(32'h0BADF00D));
    rst_n = 1'b0;
    req_valid = 1'b0; req_addr = '0; req_is64 = 1'b0; req_secure = 1'b0; rsp_ready = 1'b0;
    cfg_two_stage = 0; cfg_force_wb = 0; cfg_walk_prot = 0; cfg_big_end = 0;
    cfg_sec_below = 0; cfg_sw_ns = 0; cfg_nsw_ns = 0;
    b_s2_fault = 0; b_s2_ftype = 0; b_attr = 0; b_merr = 0; b_metype = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready === 1'b1 && busy === 1'b0, "R1 reset idle", {req_ready, busy}, 2'b10);
    chk({s2_req_valid, mem_req_valid, rsp_valid} === 3'b000, "R1 reset valids low",
        {s2_req_valid, mem_req_valid, rsp_valid}, 0);

    // Directed corner cases
    //        tag    addr            64 sec two fwb prt be sbl sw nsw s2f ft    attr   err et
    run_case("R2 bypass le64",  40'h12_3456_7808, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 4'd0, 4'hF, 0, 2'd0);
    run_case("R9 bypass be64",  40'h01_0000_1000, 1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 4'd0, 4'hF, 0, 2'd0);
    run_case("R10 lane0 be32",  40'h00_CAFE_0010, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 4'd0, 4'hF, 0, 2'd0);
    run_case("R10 lane1 le32",  40'h00_CAFE_0014, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 4'd0, 4'hF, 0, 2'd0);
    run_case("R7 sec to sec",   40'h00_0010_2000, 1, 1, 1, 0, 0, 0, 1, 0, 0, 0, 4'd0, 4'hF, 0, 2'd0);
    run_case("R7 sec to ns",    40'h00_0010_2008, 1, 1, 1, 0, 0, 0, 1, 1, 0, 0, 4'd0, 4'hF, 0, 2'd0);
    run_case("R7 ns to sec",    40'h00_0010_2010, 1, 0, 1, 0, 0, 0, 1, 0, 0, 0, 4'd0, 4'hF, 0, 2'd0);
    run_case("R7 ns to ns",     40'h00_0010_2018, 0, 0, 1, 0, 0, 1, 1, 1, 1, 0, 4'd0, 4'hF, 0, 2'd0);
    run_case("R4 s2 fault",     40'h00_0777_0040, 1, 0, 1, 0, 0, 0, 1, 0, 0, 1, 4'd9, 4'hF, 0, 2'd0);
    run_case("R5 fwb device",   40'h00_0777_0048, 1, 1, 1, 1, 1, 0, 1, 0, 0, 0, 4'd0, 4'h8, 0, 2'd0);
    run_case("R5 fwb normal",   40'h00_0777_0050, 1, 0, 1, 1, 1, 0, 0, 0, 0, 0, 4'd0, 4'h4, 0, 2'd0);
    run_case("R5 nofwb normal", 40'h00_0777_0058, 1, 0, 1, 0, 1, 0, 0, 0, 0, 0, 4'd0, 4'h8, 0, 2'd0);
    run_case("R6 nofwb device", 40'h00_0777_0060, 1, 0, 1, 0, 1, 0, 0, 0, 0, 0, 4'd0, 4'h3, 0, 2'd0);
    run_case("R6 prot off dev", 40'h00_0777_0068, 0, 0, 1, 0, 0, 1, 0, 0, 0, 0, 4'd0, 4'h0, 0, 2'd0);
    run_case("R8 bad secure",   40'h00_0777_0070, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 4'd0, 4'hF, 0, 2'd0);
    run_case("R11 mem error",   40'h00_0777_0078, 1, 0, 1, 0, 0, 1, 0, 0, 0, 0, 4'd0, 4'hF, 1, 2'd2);
    run_case("R11 bypass err",  40'h00_0777_007C, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 4'd0, 4'hF, 1, 2'd1);

    // Constrained random mix
    for (int n = 0; n < 200; n++) begin
      logic [AW-1:0] a;
      a = {$urandom, $urandom} & 40'hFF_FFFF_FFFC;
      run_case("R12 random", a, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
               $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
               ($urandom % 5) == 0, 4'($urandom % 14 + 1), 4'($urandom),
               ($urandom % 6) == 0, 2'($urandom));
    end

    finish_run();
  end

endmodule